// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block collects single-cycle event pulses from up to `N_SRC` sources and presents them to a host through one register. A write to the register loads the enable mask. Each enabled source that pulses latches a pending bit. The register's read value is the set of pending bits. A single interrupt line is raised while any pending bit is set.

A source is acknowledged by writing an enable mask that has its bit cleared. The host reads the status, drops the sources it has seen from the enable mask, and repeats until the status reads zero. It then restores the full mask. A pending bit is never created by an enable write alone.

The parameter `SRC_VALID` marks which source positions exist. Bits outside it can never be enabled and never read as 1. Reset leaves every source disabled.

Top module: `isr_ctrl`

## Requirements
- R1: During and after synchronous reset, the enable mask is all zero, `rd_data` is 0 and `irq_o` is 0.
- R2: A cycle with `wr_en` high loads the enable mask with `wr_data & SRC_VALID`. The new mask governs events from the next cycle onward.
- R3: An event pulse on source i while its enable bit is set, with no write clearing bit i in that cycle, sets `rd_data[i]` at the next clock edge. The bit stays set until it is cleared through the enable write.
- R4: `rd_data[i]` is 0 at all times for every i where `SRC_VALID[i]` is 0. With the default `SRC_VALID` = 8'hBF, this applies to bit 6.
- R5: An event on a source whose enable bit is 0 is not latched, and the status stays unchanged.
- R6: A write with `wr_data[i]` = 0 clears `rd_data[i]` at that clock edge. Pending bits whose `wr_data` bit is 1 are kept.
- R7: Re-enabling a cleared source does not set its status bit unless a new event arrives while it is enabled.
- R8: `irq_o` equals the OR of `rd_data` as it was one cycle earlier.
- R9: When an event and a write clearing the same bit occur in one cycle, the bit ends up cleared. An event on a source that is being enabled by a write in that same cycle is ignored.
- R10: During the clearing loop, an event on a source that stays enabled is latched in the same cycle as the write that clears other bits. It is then reported on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | N_SRC | New enable mask |
| evt_i | input | N_SRC | Single-cycle event pulses, one per source |
| rd_data | output | N_SRC | Pending status of enabled, valid sources |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The hardest case to reach is a single cycle in which the host's clearing write meets a fresh event. That event may land on the bit being cleared, on a bit that stays enabled, or on a bit the write is just enabling. The stimulus schedules each of these coincidences on purpose in the middle of a read-and-mask loop. A long run of random writes and event patterns is then compared against a behavioural model on every clock.

// File: rtl/isr_pkg.sv
package isr_pkg;
  // per-bit action chosen for the pending flag each cycle
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_SET   = 2'd1,
    UPD_CLEAR = 2'd2
  } pend_upd_e;
endpackage

// File: rtl/isr_enable_reg.sv
module isr_enable_reg #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] SRC_VALID = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wr_data,
  output logic [N_SRC-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= wr_data & SRC_VALID;
  end
endmodule

// File: rtl/isr_pend_bit.sv
module isr_pend_bit
  import isr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic wr_en,
  input  logic wr_keep,
  output logic pend_q
);
  pend_upd_e upd;

  always_comb begin
    if (wr_en && !wr_keep) upd = UPD_CLEAR;
    else if (set_req)      upd = UPD_SET;
    else                   upd = UPD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else begin
      case (upd)
        UPD_SET:   pend_q <= 1'b1;
        UPD_CLEAR: pend_q <= 1'b0;
        default:   pend_q <= pend_q;
      endcase
    end
  end
endmodule

// File: rtl/isr_irq_reg.sv
module isr_irq_reg #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] SRC_VALID = 8'hBF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wr_data,
  input  logic [N_SRC-1:0] evt_i,
  output logic [N_SRC-1:0] rd_data,
  output logic             irq_o
);
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] set_req;
  logic [N_SRC-1:0] pend;

  isr_enable_reg #(.N_SRC(N_SRC), .SRC_VALID(SRC_VALID)) u_en (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .en_q(en_q)
  );

  // events count only against the mask already in force
  assign set_req = evt_i & en_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    isr_pend_bit u_bit (
      .clk(clk), .rst(rst), .set_req(set_req[i]),
      .wr_en(wr_en), .wr_keep(wr_data[i]), .pend_q(pend[i])
    );
  end

  isr_irq_reg #(.N_SRC(N_SRC)) u_irq (
    .clk(clk), .rst(rst), .pend(pend), .irq_q(irq_o)
  );

  assign rd_data = pend;
endmodule

// File: rtl/isr_ctrl_chk.sv
module isr_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] SRC_VALID = 8'hBF
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [N_SRC-1:0] wr_data,
  input logic [N_SRC-1:0] evt_i,
  input logic [N_SRC-1:0] rd_data,
  input logic             irq_o
);
  // R4
  invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~SRC_VALID) == '0);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == |$past(rd_data));

  // R6
  write_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data & ~$past(wr_data)) == '0);

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~$past(rd_data) & ~$past(evt_i)) == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0 && !irq_o));
endmodule

bind isr_ctrl isr_ctrl_chk #(.N_SRC(N_SRC), .SRC_VALID(SRC_VALID)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .evt_i(evt_i), .rd_data(rd_data), .irq_o(irq_o)
);

// File: tb/sim_isr_ctrl.sv
`timescale 1ns/1ps
module sim_isr_ctrl;
  localparam int N = 8;
  localparam logic [N-1:0] VMASK = 8'hBF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] evt_i = '0;
  logic [N-1:0] rd_data;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_en = 0, m_pend = 0, m_irq = 0;

  always #4 clk = ~clk;

  isr_ctrl #(.N_SRC(N), .SRC_VALID(VMASK)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .evt_i(evt_i), .rd_data(rd_data), .irq_o(irq_o)
  );

  // behavioural reference, updated on every edge
  always @(posedge clk) begin
    int n_en, n_pend, n_irq;
    if (rst) begin
      n_en = 0; n_pend = 0; n_irq = 0;
    end else begin
      n_irq  = (m_pend != 0) ? 1 : 0;
      n_pend = m_pend | (int'(evt_i) & m_en);
      if (wr_en) n_pend = n_pend & int'(wr_data);
      n_en   = wr_en ? (int'(wr_data) & int'(VMASK)) : m_en;
    end
    m_en = n_en; m_pend = n_pend; m_irq = n_irq;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R3 R6 model status", int'(rd_data), m_pend);
      check("R8 model irq", int'(irq_o), m_irq);
    end
  end

  task automatic drive(input logic w, input logic [N-1:0] d, input logic [N-1:0] e);
    @(negedge clk);
    wr_en = w; wr_data = d; evt_i = e;
  endtask

  task automatic idle();
    drive(1'b0, '0, '0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", int'(rd_data), 0);
    check("R1 reset irq", int'(irq_o), 0);
    rst = 1'b0;
    idle();
    check("R1 after reset status", int'(rd_data), 0);
    // R2 enable everything
    drive(1'b1, 8'hFF, '0);
    // R3 R4 event on bit 0 and invalid bit 6
    drive(1'b0, '0, 8'h41);
    idle();
    check("R3 R4 status", int'(rd_data), 32'h01);
    idle();
    check("R8 irq raised", int'(irq_o), 1);
    // R6 disable bit 0
    drive(1'b1, 8'h0E, '0);
    idle();
    check("R6 cleared", int'(rd_data), 0);
    idle();
    check("R8 irq dropped", int'(irq_o), 0);
    // R5 event on disabled source
    drive(1'b0, '0, 8'h01);
    idle();
    check("R5 ignored", int'(rd_data), 0);
    // R7 re-enable without event
    drive(1'b1, 8'h0F, '0);
    idle(); idle();
    check("R7 no re-raise", int'(rd_data), 0);
    // R9 event and clearing write on bit 1
    drive(1'b1, 8'h0D, 8'h02);
    idle();
    check("R9 write wins", int'(rd_data), 0);
    // R9 event on bit 4 while it is being enabled
    drive(1'b1, 8'h1D, 8'h10);
    idle();
    check("R9 enable same cycle", int'(rd_data), 0);
    // R10 host loop
    drive(1'b0, '0, 8'h0C);
    idle();
    check("R10 first read", int'(rd_data), 32'h0C);
    drive(1'b1, 8'h11, 8'h01);
    idle();
    check("R10 new event latched", int'(rd_data), 32'h01);
    drive(1'b1, 8'h1D, '0);
    idle();
    check("R10 R7 kept after restore", int'(rd_data), 32'h01);
    drive(1'b1, 8'h1C, '0);
    idle();
    check("R6 final clear", int'(rd_data), 0);
    idle();
    check("R8 irq low", int'(irq_o), 0);
    // R2 R4 invalid bit never enabled
    drive(1'b1, 8'hFF, '0);
    drive(1'b0, '0, 8'hFF);
    idle();
    check("R2 R4 mask", int'(rd_data), int'(VMASK));
    // random stress against the model
    for (int k = 0; k < 2000; k++) begin
      drive(($urandom % 4) == 0, N'($urandom), N'($urandom & $urandom));
    end
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule